// File: doc/BRIEF.md
# Board Interrupt Status and Control Register Block

This block sits on a simple 16-bit register bus and collects up to sixteen external interrupt request lines for a host processor. Each request line passes through a two-flop synchroniser. A rising edge on the line sets a sticky status bit. The status bits are split into a lower half for sources 0 to 7 and an upper half for sources 8 to 15. The host rebuilds the full set as upper<<8 | lower, and acknowledges a source by writing a 1 to its status bit.

A single summary line tells the host that something is pending. The host samples this line on both edges, so a retrigger mode can insert a one-cycle low gap after an acknowledge while other sources remain pending; the host then sees a fresh edge. The block also holds:
- a write-only control register that selects retrigger and auto-clear-on-read, and drives a reset-disable line and a card reset line;
- a read-only version word whose fields are set by parameters.

Masking and prioritisation stay in host software.

Top module: `board_irq_ctrl`

## Requirements
- R1: After reset every status bit is 0, every control bit is 0, `host_irq_o`, `card_rst_o` and `rst_dis_o` are low, and a read of either status offset returns 0.
- R2: A rising edge on `irq_src_i[n]` sets status bit n, which is readable after the third rising clock edge that follows the input change. A line that is held high sets its bit only once; after an acknowledge the bit stays clear while the line stays high.
- R3: Status for source n < 8 is read at bit n of offset 0x0. Status for source n >= 8 is read at bit n-8 of offset 0x4. Bits 15:8 of both reads are 0.
- R4: Writing 1 to a bit at offset 0x0 or 0x4 clears that latched source at the next clock edge. Bits written as 0 are left unchanged.
- R5: If a new rising edge of a source arrives in the same cycle as a clear of that source, the bit remains set.
- R6: The control register at offset 0x2 is write-only and reads as 0. Its bits are: bit 0 retrigger, bit 1 auto-clear, bit 2 reset-disable (driven on `rst_dis_o`) and bit 3 card reset (driven on `card_rst_o`). Both outputs follow the written value from the next cycle.
- R7: Offset 0x6 returns the version word {8'b0, LOGIC_REV[2:0], BOARD_VER[1:0], BOARD_ISSUE[2:0]}, with the revision in bits 7:5, the board version in bits 4:3 and the issue in bits 2:0. A write to offset 0x6 does not change the value read back.
- R8: When retrigger is off, `host_irq_o` is high in exactly those cycles in which at least one status bit is set.
- R9: When retrigger is on and a clear drops a set bit while other bits stay pending, `host_irq_o` is low for exactly the next cycle and then high again. If the clear leaves nothing pending, `host_irq_o` goes low and stays low.
- R10: When auto-clear is on, a read of a status offset clears the bits it returned at that clock edge. When auto-clear is off, reads leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 16 | Asynchronous interrupt request lines |
| bus_addr_i | input | 3 | Register byte offset |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid while the read strobe is high, otherwise 0 |
| host_irq_o | output | 1 | Summary interrupt to the host |
| card_rst_o | output | 1 | Card reset, control bit 3 |
| rst_dis_o | output | 1 | Reset-disable, control bit 2 |

## Verification
The bench builds the block with its default split of two 8-bit halves, which gives 16 sources. It overrides the version parameters with 6, 1 and 3, so that every version field holds a non-zero value that differs from the defaults. With only sixteen sources, the bench can sweep every source through latch, mapping, held-level and acknowledge, and check each case against the expected one-hot value it computes. The small size also brings the same-cycle edge-and-clear race, the retrigger gap with and without remaining pending bits, and auto-clear reads of both halves within reach of directed checks.

// File: rtl/birq_pkg.sv
package birq_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_STAT_LO = 3'h0;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 3'h2;
  localparam logic [REG_AW-1:0] OFS_STAT_HI = 3'h4;
  localparam logic [REG_AW-1:0] OFS_VER     = 3'h6;
  localparam int CTRL_W = 4;

  // bit order matters: software writes retrigger at bit 0 .. card reset at bit 3
  typedef struct packed {
    logic card_rst;
    logic rst_dis;
    logic auto_clr;
    logic retrig;
  } ctrl_t;

  function automatic logic [7:0] pack_version(input logic [2:0] rev,
                                              input logic [1:0] ver,
                                              input logic [2:0] iss);
    return {rev, ver, iss};
  endfunction

  function automatic logic [REG_AW-1:0] half_offset(input int h);
    return (h == 0) ? OFS_STAT_LO : OFS_STAT_HI;
  endfunction
endpackage

// File: rtl/birq_edge_sync.sv
module birq_edge_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;

  // R2: one edge per transition, never two cycles in a row on one bit
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/birq_stat_bank.sv
module birq_stat_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] stat_nxt_o,
  output logic [W-1:0] drop_o
);
  logic [W-1:0] stat_q;

  // a set in the same cycle wins over a clear
  assign stat_nxt_o = (stat_q & ~clr_i) | set_i;
  assign drop_o     = stat_q & clr_i & ~set_i;
  assign stat_o     = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt_o;
  end

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((stat_o & $past(clr_i & ~set_i)) == '0));
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i)));
endmodule

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
  import birq_pkg::*;
#(
  parameter int          HALF_W      = 8,
  parameter int          DATA_W      = 16,
  parameter logic [2:0]  LOGIC_REV   = 3'd5,
  parameter logic [1:0]  BOARD_VER   = 2'd2,
  parameter logic [2:0]  BOARD_ISSUE = 3'd1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*HALF_W-1:0]   irq_src_i,
  input  logic [REG_AW-1:0]     bus_addr_i,
  input  logic                  bus_rd_i,
  input  logic                  bus_wr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  host_irq_o,
  output logic                  card_rst_o,
  output logic                  rst_dis_o
);
  localparam int NUM_HALF = 2;
  localparam int NUM_SRC  = NUM_HALF * HALF_W;
  localparam logic [7:0] VERSION = pack_version(LOGIC_REV, BOARD_VER, BOARD_ISSUE);

  ctrl_t               ctrl_q;
  logic [NUM_SRC-1:0]  rise_w, stat_w, stat_nxt_w, drop_w, clr_w;
  logic                gap_q;
  logic                wr_ctrl_w, any_pend_w, any_drop_w, nxt_pend_w;

  birq_edge_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(irq_src_i), .rise_o(rise_w));

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic hit_w;
    logic [HALF_W-1:0] st_w;
    assign hit_w = (bus_addr_i == half_offset(h));
    assign st_w  = stat_w[h*HALF_W +: HALF_W];
    assign clr_w[h*HALF_W +: HALF_W] =
        ((bus_wr_i && hit_w) ? bus_wdata_i[HALF_W-1:0] : '0) |
        ((bus_rd_i && hit_w && ctrl_q.auto_clr) ? st_w : '0);

    birq_stat_bank #(.W(HALF_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_i(rise_w[h*HALF_W +: HALF_W]),
      .clr_i(clr_w[h*HALF_W +: HALF_W]),
      .stat_o(stat_w[h*HALF_W +: HALF_W]),
      .stat_nxt_o(stat_nxt_w[h*HALF_W +: HALF_W]),
      .drop_o(drop_w[h*HALF_W +: HALF_W]));
  end

  assign wr_ctrl_w  = bus_wr_i && (bus_addr_i == OFS_CTRL);
  assign any_pend_w = |stat_w;
  assign any_drop_w = |drop_w;
  assign nxt_pend_w = |stat_nxt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gap_q  <= 1'b0;
    end else begin
      if (wr_ctrl_w) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
      gap_q <= ctrl_q.retrig && any_drop_w && nxt_pend_w;
    end
  end

  assign host_irq_o = any_pend_w && !gap_q;
  assign card_rst_o = ctrl_q.card_rst;
  assign rst_dis_o  = ctrl_q.rst_dis;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      unique case (bus_addr_i)
        OFS_STAT_LO: bus_rdata_o[HALF_W-1:0] = stat_w[HALF_W-1:0];
        OFS_STAT_HI: bus_rdata_o[HALF_W-1:0] = stat_w[NUM_SRC-1:HALF_W];
        OFS_VER:     bus_rdata_o[7:0]        = VERSION;
        default:     bus_rdata_o             = '0;
      endcase
    end
  end

  a_r8_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w == '0) |-> !host_irq_o);
  a_r6_card_rst_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_w |=> (card_rst_o == $past(bus_wdata_i[3]) && rst_dis_o == $past(bus_wdata_i[2])));
  a_r9_retrig_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.retrig && any_drop_w && nxt_pend_w) |=> !host_irq_o);
  a_r10_autoclr_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == OFS_STAT_LO && ctrl_q.auto_clr && rise_w[HALF_W-1:0] == '0)
      |=> (stat_w[HALF_W-1:0] == '0));
endmodule

// File: tb/board_irq_ctrl_tb.sv
`timescale 1ns/1ps
module board_irq_ctrl_tb_top;
  localparam logic [2:0] T_REV = 3'd6;
  localparam logic [1:0] T_VER = 2'd1;
  localparam logic [2:0] T_ISS = 3'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] irq_src = '0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        host_irq, card_rst, rst_dis;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  board_irq_ctrl #(.LOGIC_REV(T_REV), .BOARD_VER(T_VER), .BOARD_ISSUE(T_ISS)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .bus_addr_i(addr),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .host_irq_o(host_irq), .card_rst_o(card_rst), .rst_dis_o(rst_dis));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int k = 1);
    for (int i = 0; i < k; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    tick();
    rd = 1'b0;
  endtask

  // expected halves for a single source, computed arithmetically
  function automatic logic [15:0] lo_of(input int n);
    return (n < 8) ? 16'(1 << n) : 16'h0;
  endfunction
  function automatic logic [15:0] hi_of(input int n);
    return (n >= 8) ? 16'(1 << (n - 8)) : 16'h0;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    @(negedge clk); tick(2);
    rst_n = 1'b1; tick();

    // R1 reset state
    chk("R1 host_irq", {15'b0, host_irq}, 16'h0);
    chk("R1 card_rst", {15'b0, card_rst}, 16'h0);
    chk("R1 rst_dis", {15'b0, rst_dis}, 16'h0);
    bus_read(3'h0, v); chk("R1 lo", v, 16'h0);
    bus_read(3'h4, v); chk("R1 hi", v, 16'h0);

    // R7 version, R6 ctrl reads 0
    bus_read(3'h6, v);
    chk("R7 version", v, 16'(T_REV) * 32 + 16'(T_VER) * 8 + 16'(T_ISS));
    bus_write(3'h6, 16'hFFFF);
    bus_read(3'h6, v2); chk("R7 write ignored", v2, v);
    bus_read(3'h2, v); chk("R6 ctrl reads zero", v, 16'h0);

    // R2/R3/R4/R8 sweep over every source
    for (int n = 0; n < 16; n++) begin
      irq_src[n] = 1'b1;
      tick(2);
      bus_read(3'h0, v); chk("R2 not yet latched", v | 16'h0, 16'h0);
      tick(1);
      bus_read(3'h0, v); chk("R3 lo map", v, lo_of(n));
      bus_read(3'h4, v); chk("R3 hi map", v, hi_of(n));
      chk("R8 irq high", {15'b0, host_irq}, 16'h1);
      bus_write((n < 8) ? 3'h0 : 3'h4, 16'hFFFF ^ ((n < 8) ? lo_of(n) : hi_of(n)));
      bus_read((n < 8) ? 3'h0 : 3'h4, v);
      chk("R4 zero bits keep", v, (n < 8) ? lo_of(n) : hi_of(n));
      bus_write((n < 8) ? 3'h0 : 3'h4, (n < 8) ? lo_of(n) : hi_of(n));
      chk("R8 irq low empty", {15'b0, host_irq}, 16'h0);
      tick(4);
      bus_read(3'h0, v); bus_read(3'h4, v2);
      chk("R2 held level no reset", v | v2, 16'h0);
      irq_src[n] = 1'b0;
      tick(3);
    end

    // R8 no gap without retrigger
    irq_src[1] = 1'b1; irq_src[2] = 1'b1; tick(3);
    irq_src[1] = 1'b0; irq_src[2] = 1'b0; tick(3);
    bus_write(3'h0, 16'h0002);
    chk("R8 stays high, no retrigger", {15'b0, host_irq}, 16'h1);
    bus_write(3'h0, 16'h0004);

    // R5 clear coinciding with a new edge
    irq_src[3] = 1'b1; tick(3); irq_src[3] = 1'b0; tick(3);
    irq_src[3] = 1'b1; tick(2);
    bus_write(3'h0, 16'h0008);
    bus_read(3'h0, v); chk("R5 set wins", v, 16'h0008);
    irq_src[3] = 1'b0; tick(3);
    bus_write(3'h0, 16'h0008);
    bus_read(3'h0, v); chk("R5 later clear", v, 16'h0);

    // R9 retrigger
    bus_write(3'h2, 16'h0001);
    irq_src[0] = 1'b1; irq_src[9] = 1'b1; tick(3);
    irq_src[0] = 1'b0; irq_src[9] = 1'b0; tick(3);
    bus_write(3'h0, 16'h0001);
    chk("R9 gap low", {15'b0, host_irq}, 16'h0);
    tick();
    chk("R9 high again", {15'b0, host_irq}, 16'h1);
    bus_write(3'h4, 16'h0002);
    chk("R9 empty low", {15'b0, host_irq}, 16'h0);
    tick();
    chk("R9 stays low", {15'b0, host_irq}, 16'h0);

    // R10 auto-clear off then on
    bus_write(3'h2, 16'h0000);
    irq_src[5] = 1'b1; irq_src[12] = 1'b1; tick(3);
    irq_src[5] = 1'b0; irq_src[12] = 1'b0; tick(3);
    bus_read(3'h0, v); bus_read(3'h0, v2);
    chk("R10 off keeps", v2, 16'h0020);
    bus_write(3'h2, 16'h0002);
    bus_read(3'h0, v); chk("R10 returned lo", v, 16'h0020);
    bus_read(3'h0, v); chk("R10 cleared lo", v, 16'h0);
    bus_read(3'h4, v); chk("R10 returned hi", v, 16'h0010);
    bus_read(3'h4, v); chk("R10 cleared hi", v, 16'h0);

    // R6 control outputs
    bus_write(3'h2, 16'h0008);
    chk("R6 card_rst", {14'b0, rst_dis, card_rst}, 16'h1);
    bus_write(3'h2, 16'h0004);
    chk("R6 rst_dis", {14'b0, rst_dis, card_rst}, 16'h2);
    bus_read(3'h2, v); chk("R6 write-only", v, 16'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule